// File: doc/BRIEF.md
# DDR3 Burst Column Order Generator

This block turns one column access into the sequence of low column indices that the data beats of a DDR3 burst occupy. A single-cycle start request carries the access configuration: full eight-beat burst or four-beat chop, read or write, wrapping (sequential) or XOR (interleaved) ordering, and the three low bits of the starting column. Once launched, the block presents one beat per clock for eight clocks. For each beat it gives the 3-bit column index, a flag saying the beat carries real data, and a flag saying the data and strobe drivers must float.

A chopped burst still uses the full eight-clock slot, so the timing of a chop is the same as that of a full burst. Only its second half is masked: it is floated on reads and ignored on writes. Writes ignore some or all of the starting column bits, so the beat order depends on the command direction and not only on the address. The configuration is captured when a start is accepted. A start that arrives while a burst is still running is dropped.

Top module: `burst_order_gen`

## Requirements
- R1: Full-burst read, wrapping order (interleave=0): the column of beat i (0..7) is the starting group of four, with bit 2 inverted for i >= 4, plus ((start_col[1:0] + i) mod 4). A start of 5 gives 5,6,7,4,1,2,3,0.
- R2: Full-burst read, XOR order (interleave=1): the column of beat i is start_col XOR i. A start of 5 gives 5,4,7,6,1,0,3,2.
- R3: Chopped read (chop4=1, write_cmd=0): beats 0..3 follow the R1 or R2 rule. Beats 4..7 have beat_hiz=1, beat_valid=0 and beat_col=0.
- R4: Chopped write (chop4=1, write_cmd=1): start_col[1:0] and interleave have no effect. Beats 0..3 carry {start_col[2], i[1:0]}. Beats 4..7 have beat_valid=0, beat_hiz=0 and beat_col=0.
- R5: Full-burst write: start_col and interleave have no effect. Beat i carries column i for i = 0..7, with beat_valid=1 and beat_hiz=0.
- R6: A start that is accepted at clock edge k shows beat 0 after edge k and advances one beat per edge. busy stays high for exactly eight clocks, the same for chopped and full bursts.
- R7: start is accepted only while busy is low. A start seen while busy is high, including in the last beat, has no effect. A start held high therefore launches bursts separated by one idle clock.
- R8: While idle, and after a synchronous active-high reset (which also cancels a running burst), busy=0, beat_col=0, beat_valid=0 and beat_hiz=0.
- R9: chop4, write_cmd, interleave and start_col are sampled only at the accepted start. Changes during a burst do not alter its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken when busy is low |
| chop4 | input | 1 | 1 = four-beat chop, 0 = eight-beat burst |
| write_cmd | input | 1 | 1 = write, 0 = read |
| interleave | input | 1 | 1 = XOR order, 0 = wrapping order |
| start_col | input | 3 | Low bits of the starting column |
| busy | output | 1 | High during the eight beat clocks |
| beat_col | output | 3 | Column index of the current beat |
| beat_valid | output | 1 | Current beat carries data |
| beat_hiz | output | 1 | Data and strobe drivers float for this beat |

## Verification
Two events can land in the same cycle: the final beat of a burst and a new start request, and a running burst and a start request with a different configuration. The bench holds start high across whole bursts and toggles every configuration input while a burst runs. The cycle-by-cycle model predicts that the request in the last beat is dropped, that the next launch comes one idle clock later, and that the running burst keeps the order it was launched with. Every output is compared against that model on every clock.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int SLOT_BEATS = 8;
    localparam int CHOP_BEATS = 4;
    localparam int COL_W      = $clog2(SLOT_BEATS);
    localparam int BEAT_W     = COL_W;
    localparam int GRP_W      = $clog2(CHOP_BEATS);

    typedef enum logic { LEN_FULL = 1'b0, LEN_CHOP = 1'b1 } len_e;
    typedef enum logic { DIR_RD   = 1'b0, DIR_WR   = 1'b1 } dir_e;
    typedef enum logic { ORD_WRAP = 1'b0, ORD_XOR  = 1'b1 } order_e;

    typedef struct packed {
        len_e             len;
        dir_e             dir;
        order_e           ord;
        logic [COL_W-1:0] scol;
    } burst_cfg_t;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             valid;
        logic             hiz;
    } beat_out_t;

    localparam beat_out_t BEAT_IDLE = '{col: '0, valid: 1'b0, hiz: 1'b0};

    // wrap the low bits inside the group, swap group in the second half
    function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] scol,
                                                  input logic [BEAT_W-1:0] beat);
        logic [COL_W-GRP_W-1:0] hi;
        logic [GRP_W-1:0]       lo;
        hi = scol[COL_W-1:GRP_W] ^ beat[BEAT_W-1:GRP_W];
        lo = scol[GRP_W-1:0] + beat[GRP_W-1:0];
        return {hi, lo};
    endfunction

    function automatic logic [COL_W-1:0] xor_col(input logic [COL_W-1:0] scol,
                                                 input logic [BEAT_W-1:0] beat);
        return scol ^ beat;
    endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  burst_cfg_t cfg_in,
    output burst_cfg_t cfg_q,
    output burst_cfg_t cfg_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{len: LEN_FULL, dir: DIR_RD, ord: ORD_WRAP, scol: '0};
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

    // the launching beat uses the incoming configuration directly
    assign cfg_sel = load ? cfg_in : cfg_q;

endmodule

// File: rtl/beat_seq.sv
module beat_seq
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output logic              load,
    output logic              next_active,
    output logic [BEAT_W-1:0] next_beat
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(SLOT_BEATS - 1);

    logic at_last;

    always_comb begin
        load        = start & ~busy;
        at_last     = busy & (beat == LAST_BEAT);
        next_active = load | (busy & ~at_last);
        next_beat   = load ? '0 : beat + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            beat <= '0;
        end else begin
            busy <= next_active;
            beat <= next_active ? next_beat : '0;
        end
    end

    assert_busy_step_R6: assert property (@(posedge clk) disable iff (rst)
        busy && (beat != LAST_BEAT) |=> busy && (beat == $past(beat) + 1'b1));

    assert_busy_end_R6: assert property (@(posedge clk) disable iff (rst)
        busy && (beat == LAST_BEAT) |=> !busy);

    assert_launch_R6: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy && (beat == '0));

endmodule

// File: rtl/beat_map.sv
module beat_map
    import burst_pkg::*;
(
    input  burst_cfg_t        cfg,
    input  logic [BEAT_W-1:0] beat,
    output beat_out_t         o
);

    logic in_tail;

    always_comb begin
        in_tail = (beat >= BEAT_W'(CHOP_BEATS));
        o       = BEAT_IDLE;
        if (cfg.len == LEN_CHOP && in_tail) begin
            o.hiz = (cfg.dir == DIR_RD);
        end else if (cfg.dir == DIR_WR) begin
            o.valid = 1'b1;
            o.col   = (cfg.len == LEN_CHOP) ?
                      {cfg.scol[COL_W-1:GRP_W], beat[GRP_W-1:0]} : beat;
        end else begin
            o.valid = 1'b1;
            o.col   = (cfg.ord == ORD_XOR) ? xor_col(cfg.scol, beat)
                                           : wrap_col(cfg.scol, beat);
        end
    end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             chop4,
    input  logic             write_cmd,
    input  logic             interleave,
    input  logic [COL_W-1:0] start_col,
    output logic             busy,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_valid,
    output logic             beat_hiz
);

    burst_cfg_t        cfg_in, cfg_q, cfg_sel;
    beat_out_t         mapped, out_q;
    logic              load, next_active;
    logic [BEAT_W-1:0] beat_cur, next_beat;

    always_comb begin
        cfg_in.len  = len_e'(chop4);
        cfg_in.dir  = dir_e'(write_cmd);
        cfg_in.ord  = order_e'(interleave);
        cfg_in.scol = start_col;
    end

    beat_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .busy        (busy),
        .beat        (beat_cur),
        .load        (load),
        .next_active (next_active),
        .next_beat   (next_beat)
    );

    burst_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .cfg_sel (cfg_sel)
    );

    beat_map u_map (
        .cfg  (cfg_sel),
        .beat (next_beat),
        .o    (mapped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= BEAT_IDLE;
        end else begin
            out_q <= next_active ? mapped : BEAT_IDLE;
        end
    end

    assign beat_col   = out_q.col;
    assign beat_valid = out_q.valid;
    assign beat_hiz   = out_q.hiz;

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !beat_valid && !beat_hiz && (beat_col == '0));

    assert_hiz_excl_R3: assert property (@(posedge clk) disable iff (rst)
        beat_hiz |-> !beat_valid && busy);

    assert_write_no_hiz_R4: assert property (@(posedge clk) disable iff (rst)
        busy && (cfg_q.dir == DIR_WR) |-> !beat_hiz);

    assert_chop_tail_R3: assert property (@(posedge clk) disable iff (rst)
        busy && (cfg_q.len == LEN_CHOP) && (beat_cur >= BEAT_W'(CHOP_BEATS)) |-> !beat_valid);

    assert_full_all_valid_R5: assert property (@(posedge clk) disable iff (rst)
        busy && (cfg_q.len == LEN_FULL) |-> beat_valid);

endmodule

// File: tb/sim_burst_order_gen.sv
module sim_burst_order_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       chop4 = 1'b0;
    logic       write_cmd = 1'b0;
    logic       interleave = 1'b0;
    logic [2:0] start_col = 3'd0;
    logic       busy;
    logic [2:0] beat_col;
    logic       beat_valid;
    logic       beat_hiz;

    always #2 clk = ~clk;  // 250 MHz

    burst_order_gen u0 (
        .clk(clk), .rst(rst), .start(start), .chop4(chop4),
        .write_cmd(write_cmd), .interleave(interleave), .start_col(start_col),
        .busy(busy), .beat_col(beat_col), .beat_valid(beat_valid), .beat_hiz(beat_hiz)
    );

    typedef struct {
        int col;
        bit valid;
        bit hiz;
        bit busy;
        int tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_checks = 0;
    int   n_fails  = 0;
    int   phase_tag = 0;
    int   cyc = 0;

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic exp_t idle_beat();
        exp_t e;
        e.col = 0; e.valid = 0; e.hiz = 0; e.busy = 0; e.tag = 8;
        return e;
    endfunction

    // expected beat i of a burst, written from the requirement text
    function automatic exp_t make_beat(bit ch, bit wr, bit il, int s, int i);
        exp_t e;
        e.busy = 1;
        if (ch && i >= 4) begin
            e.col = 0; e.valid = 0; e.hiz = !wr; e.tag = wr ? 4 : 3;
        end else if (wr) begin
            e.valid = 1; e.hiz = 0;
            e.col = ch ? ((s / 4) * 4 + i) : i;
            e.tag = ch ? 4 : 5;
        end else begin
            e.valid = 1; e.hiz = 0;
            if (il) e.col = s ^ i;
            else    e.col = (((s / 4) * 4) ^ ((i / 4) * 4)) + ((s + i) % 4);
            e.tag = ch ? 3 : (il ? 2 : 1);
        end
        if (phase_tag != 0) e.tag = phase_tag;
        return e;
    endfunction

    // reference model: advances on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = idle_beat();
        end else if (q.size() > 0) begin
            cur = q.pop_front();
        end else if (start && !cur.busy) begin
            for (int i = 0; i < 8; i++)
                q.push_back(make_beat(chop4, write_cmd, interleave, int'(start_col), i));
            cur = q.pop_front();
        end else begin
            cur = idle_beat();
        end
    end

    task automatic chk(input bit ok, input int t, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (time %0t)", tag_name(t), what, act, exp, $time);
        end
    endtask

    // compare every output away from the rising edge
    always @(negedge clk) begin
        if (!rst && cyc > 2) begin
            chk(busy == cur.busy, 6, "busy", int'(busy), int'(cur.busy));
            chk(int'(beat_col) == cur.col, cur.tag, "beat_col", int'(beat_col), cur.col);
            chk(beat_valid == cur.valid, cur.tag, "beat_valid", int'(beat_valid), int'(cur.valid));
            chk(beat_hiz == cur.hiz, cur.tag, "beat_hiz", int'(beat_hiz), int'(cur.hiz));
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fails++;
            $display("FAIL R6 watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    task automatic set_cfg(bit ch, bit wr, bit il, int s);
        chop4 = ch; write_cmd = wr; interleave = il; start_col = 3'(s);
    endtask

    task automatic one_burst(bit ch, bit wr, bit il, int s);
        @(negedge clk);
        set_cfg(ch, wr, il, s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(!busy && beat_col == 3'd0 && !beat_valid && !beat_hiz, 8, "reset outputs",
            int'({busy, beat_col, beat_valid, beat_hiz}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4 R5: every mode with every start column
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 8; s++)
                one_burst(m[2], m[1], m[0], s);

        // R7: start held high, bursts back to back
        phase_tag = 7;
        @(negedge clk);
        set_cfg(1'b0, 1'b0, 1'b1, 3);
        start = 1'b1;
        repeat (30) @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);

        // R9 and R7: new start and flipped config during a running burst
        phase_tag = 9;
        for (int s = 0; s < 8; s += 3) begin
            @(negedge clk);
            set_cfg(1'b1, 1'b0, 1'b0, s);
            start = 1'b1;
            @(negedge clk);
            for (int k = 0; k < 5; k++) begin
                set_cfg(k[0], ~k[0], k[1], 7 - s - k);
                @(negedge clk);
            end
            start = 1'b0;
            repeat (6) @(negedge clk);
        end

        // R8: reset cancels a running burst
        phase_tag = 8;
        @(negedge clk);
        set_cfg(1'b0, 1'b0, 1'b0, 6);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !beat_valid && beat_col == 3'd0, 8, "reset mid-burst",
            int'({busy, beat_col, beat_valid}), 0);
        rst = 1'b0;
        phase_tag = 0;
        one_burst(1'b0, 1'b0, 1'b0, 5);
        repeat (3) @(negedge clk);
        summary();
    end

endmodule